// File: doc/BRIEF.md
# Sampling Host Controller for a Parallel SAR Converter

This block sits on the host side of a parallel successive-approximation converter and runs the whole sampling cycle without software help. When sampling is enabled it issues an active-low start-convert pulse once per programmed sample period. It then waits for the converter's busy line to drop and rise again, and performs a chip-select and read access. It captures the data bus on the last read cycle and presents the word with a one-cycle valid strobe. Before another start is allowed, it holds a quiet window after the read.

The same controller also handles the converter's two low-power states. A power request input asks for nap or standby. The controller only acts on the request between conversions, and then drives the matching power pin high. When the request is withdrawn, it holds off new starts for a wake-up time counted in clock cycles. That time depends on which state is being left and, for standby, on whether the internal or an external reference is in use. A not-ready output is high while asleep and while a wake-up wait runs. A nap request made while the internal reference is selected is refused: the nap pin stays low, sampling carries on, and a reject flag is raised.

Top module: `adc_sample_host`

## Requirements
- R1: With `sample_en` high and no power request, `cnv_n` goes low for exactly `T_CNV` cycles, and consecutive falling edges of `cnv_n` are exactly `period` cycles apart whenever `period` exceeds the length of one conversion-and-read cycle.
- R2: `cs_n` and `rd_n` go low together only after `busy` has gone low and then high again. They go low in the cycle that follows the first clock edge at which `busy` is seen high, stay low for exactly `T_RD` cycles, and are never low while `busy` is low.
- R3: On the last read cycle the controller captures `db`. It presents `db[11:0]` on `data` and `db[12]` on `ovr`, with `data_vld` high for exactly one cycle per conversion.
- R4: After `cs_n` rises, at least `T_QUIET`+1 cycles pass before the next falling edge of `cnv_n`. With back-to-back sampling (`period` = 1) the gap is exactly `T_QUIET`+1.
- R5: `pwr_req[0]` high with `pwr_req[1]` low and `ref_internal` low puts the controller in nap. `nap_pin` is high, `not_ready` is high and no start is issued.
- R6: After `nap_pin` falls, `not_ready` stays high for exactly `T_NAP_WAKE` cycles, and the earliest next falling edge of `cnv_n` comes `T_NAP_WAKE`+1 cycles after `nap_pin` falls.
- R7: A nap request while `ref_internal` is high is refused. `nap_pin` never rises, `nap_reject` is high, and sampling continues.
- R8: `pwr_req[1]` high requests standby, and standby takes priority over nap, including a move from nap into standby. `nap_pin` and `stby_pin` are never high together.
- R9: After `stby_pin` falls, the next falling edge of `cnv_n` comes `T_STBY_WAKE_INT`+1 cycles later if `ref_internal` was high at exit, or `T_STBY_WAKE_EXT`+1 cycles later if it was low.
- R10: A power request that arrives during a conversion does not cut it short. The word of that conversion is delivered with `data_vld` before the power pin rises.
- R11: During reset, `cnv_n`, `cs_n` and `rd_n` are high, and `nap_pin`, `stby_pin`, `data_vld` and `not_ready` are low.
- R12: With `sample_en` low, no start-convert pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Enables periodic sampling |
| period | input | PER_W | Sample period in cycles (0 treated as 1) |
| ref_internal | input | 1 | High when the internal reference is selected |
| pwr_req | input | 2 | Bit 0 requests nap, bit 1 requests standby (bit 1 wins) |
| cnv_n | output | 1 | Start-convert, active low; falling edge starts |
| busy | input | 1 | Converter busy, low during conversion |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| db | input | DW | Converter data bus; top bit is overrange |
| nap_pin | output | 1 | Drives the converter nap input |
| stby_pin | output | 1 | Drives the converter standby input |
| data | output | DW-1 | Captured conversion word |
| ovr | output | 1 | Captured overrange bit |
| data_vld | output | 1 | One-cycle strobe for `data` and `ovr` |
| not_ready | output | 1 | High while asleep or waiting for wake-up |
| nap_reject | output | 1 | High while a nap request is refused |

## Verification
Two things can meet in the same idle cycle: the expiry of the period timer and an incoming power request. A power request can also coincide with a conversion that is still in flight. The bench raises a nap request half a cycle after a start edge, while the converter model is still busy. It then judges the outcome by whether that conversion's word is strobed out before the nap pin rises, and by whether any start appears while the pin is high. Sleep exits are timed against a pending period, so the wake-up wait alone decides when the next start falls.

// File: rtl/adc_sample_host.sv
`timescale 1ns/1ps
module adc_sample_host #(
  parameter int PER_W           = 16,
  parameter int DW              = 13,
  parameter int T_CNV           = 2,
  parameter int T_RD            = 3,
  parameter int T_QUIET         = 4,
  parameter int T_NAP_WAKE      = 30,
  parameter int T_STBY_WAKE_INT = 50_000_000,
  parameter int T_STBY_WAKE_EXT = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [PER_W-1:0] period,
  input  logic             ref_internal,
  input  logic [1:0]       pwr_req,
  output logic             cnv_n,
  input  logic             busy,
  output logic             cs_n,
  output logic             rd_n,
  input  logic [DW-1:0]    db,
  output logic             nap_pin,
  output logic             stby_pin,
  output logic [DW-2:0]    data,
  output logic             ovr,
  output logic             data_vld,
  output logic             not_ready,
  output logic             nap_reject
);

  localparam int TM0  = (T_CNV > T_RD) ? T_CNV : T_RD;
  localparam int TM1  = (TM0 > T_QUIET) ? TM0 : T_QUIET;
  localparam int TM2  = (TM1 > T_NAP_WAKE) ? TM1 : T_NAP_WAKE;
  localparam int TM3  = (TM2 > T_STBY_WAKE_INT) ? TM2 : T_STBY_WAKE_INT;
  localparam int TMAX = (TM3 > T_STBY_WAKE_EXT) ? TM3 : T_STBY_WAKE_EXT;
  localparam int CW   = $clog2(TMAX + 1);

  localparam logic [CW-1:0] L_CNV = CW'(T_CNV - 1);
  localparam logic [CW-1:0] L_RD  = CW'(T_RD - 1);
  localparam logic [CW-1:0] L_QT  = CW'(T_QUIET - 1);
  localparam logic [CW-1:0] L_NAP = CW'(T_NAP_WAKE - 1);
  localparam logic [CW-1:0] L_SI  = CW'(T_STBY_WAKE_INT - 1);
  localparam logic [CW-1:0] L_SE  = CW'(T_STBY_WAKE_EXT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CNV, S_WLO, S_WHI, S_RD, S_QUIET, S_NAP, S_STBY, S_WAKE
  } st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [PER_W-1:0] per_cnt;

  wire want_nap  = pwr_req[0] & ~pwr_req[1];
  wire want_stby = pwr_req[1];
  wire due       = (period == '0) ||
                   (({1'b0, per_cnt} + {{PER_W{1'b0}}, 1'b1}) >= {1'b0, period});

  assign cnv_n     = (state != S_CNV);
  assign cs_n      = (state != S_RD);
  assign rd_n      = (state != S_RD);
  assign nap_pin   = (state == S_NAP);
  assign stby_pin  = (state == S_STBY);
  assign not_ready = (state == S_NAP) || (state == S_STBY) || (state == S_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      per_cnt    <= '1;
      data       <= '0;
      ovr        <= 1'b0;
      data_vld   <= 1'b0;
      nap_reject <= 1'b0;
    end else begin
      data_vld   <= 1'b0;
      nap_reject <= want_nap & ref_internal;
      if (per_cnt != '1) per_cnt <= per_cnt + PER_W'(1);
      if (cnt != '0) cnt <= cnt - CW'(1);
      case (state)
        S_IDLE:
          if (want_stby) state <= S_STBY;
          else if (want_nap && !ref_internal) state <= S_NAP;
          else if (sample_en && due) begin
            state   <= S_CNV;
            cnt     <= L_CNV;
            per_cnt <= '0;
          end
        S_CNV:  if (cnt == '0) state <= S_WLO;
        S_WLO:  if (!busy) state <= S_WHI;
        S_WHI:
          if (busy) begin
            state <= S_RD;
            cnt   <= L_RD;
          end
        S_RD:
          if (cnt == '0) begin
            data     <= db[DW-2:0];
            ovr      <= db[DW-1];
            data_vld <= 1'b1;
            state    <= S_QUIET;
            cnt      <= L_QT;
          end
        S_QUIET: if (cnt == '0) state <= S_IDLE;
        S_NAP:
          if (want_stby) state <= S_STBY;
          else if (!want_nap || ref_internal) begin
            state <= S_WAKE;
            cnt   <= L_NAP;
          end
        S_STBY:
          if (!want_stby) begin
            state <= S_WAKE;
            cnt   <= ref_internal ? L_SI : L_SE;
          end
        S_WAKE: if (cnt == '0) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_sample_host_chk.sv
`timescale 1ns/1ps
module adc_sample_host_chk #(
  parameter int T_CNV      = 2,
  parameter int T_QUIET    = 4,
  parameter int T_NAP_WAKE = 30
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_n,
  input logic cs_n,
  input logic rd_n,
  input logic busy,
  input logic nap_pin,
  input logic stby_pin,
  input logic data_vld,
  input logic not_ready,
  input logic ref_internal
);

  logic [31:0] qcnt, wcnt, lcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt <= '1;
      wcnt <= '1;
      lcnt <= '0;
    end else begin
      qcnt <= !cs_n ? '0 : ((qcnt == '1) ? qcnt : qcnt + 32'd1);
      wcnt <= nap_pin ? '0 : ((wcnt == '1) ? wcnt : wcnt + 32'd1);
      lcnt <= cnv_n ? '0 : lcnt + 32'd1;
    end
  end

  p_cnv_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n) |-> lcnt == 32'(T_CNV));

  p_read_busy_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> busy);

  p_vld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |=> !data_vld);

  p_quiet_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> qcnt >= 32'(T_QUIET));

  p_no_start_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> !$past(not_ready) && !nap_pin && !stby_pin);

  p_nap_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> wcnt >= 32'(T_NAP_WAKE));

  p_nap_ext_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nap_pin) |-> !$past(ref_internal));

  p_pins_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nap_pin && stby_pin));

endmodule

bind adc_sample_host adc_sample_host_chk #(
  .T_CNV(T_CNV), .T_QUIET(T_QUIET), .T_NAP_WAKE(T_NAP_WAKE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .cs_n(cs_n), .rd_n(rd_n),
  .busy(busy), .nap_pin(nap_pin), .stby_pin(stby_pin), .data_vld(data_vld),
  .not_ready(not_ready), .ref_internal(ref_internal)
);

// File: tb/sim_adc_sample_host.sv
`timescale 1ns/1ps
module sim_adc_sample_host;
  localparam int T_CNV = 2, T_RD = 3, T_QUIET = 4, T_NAP = 30, T_SI = 400, T_SE = 120;
  localparam int CONV = 8;

  logic clk = 0, rst_n = 0, sample_en = 0, ref_internal = 0, busy = 1;
  logic [15:0] period = 16'd40;
  logic [1:0]  pwr_req = 2'b00;
  logic [12:0] db = '0;
  logic cnv_n, cs_n, rd_n, nap_pin, stby_pin, ovr, data_vld, not_ready, nap_reject;
  logic [11:0] data;

  always #5 clk = ~clk;

  adc_sample_host #(
    .PER_W(16), .DW(13), .T_CNV(T_CNV), .T_RD(T_RD), .T_QUIET(T_QUIET),
    .T_NAP_WAKE(T_NAP), .T_STBY_WAKE_INT(T_SI), .T_STBY_WAKE_EXT(T_SE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .period(period),
    .ref_internal(ref_internal), .pwr_req(pwr_req), .cnv_n(cnv_n), .busy(busy),
    .cs_n(cs_n), .rd_n(rd_n), .db(db), .nap_pin(nap_pin), .stby_pin(stby_pin),
    .data(data), .ovr(ovr), .data_vld(data_vld), .not_ready(not_ready),
    .nap_reject(nap_reject)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mkw(input int n);
    return 13'((n * 613 + 77) ^ (n << 9));
  endfunction

  int nconv = 0;
  initial begin : conv_model
    bit prev = 1, on = 0;
    int k = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin on = 0; busy = 1; end
      else if (!on && prev && !cnv_n) begin on = 1; k = CONV; busy = 0; end
      else if (on) begin
        k--;
        if (k == 0) begin on = 0; busy = 1; db = mkw(nconv); nconv++; end
      end
      prev = cnv_n;
    end
  end

  longint cyc = 0, t_cnv = 0, t_cnv_prev = 0, t_csr = 0, t_napf = 0, t_stbyf = 0;
  longint t_nrf = 0, t_busyr = 0, t_rdf = 0;
  int n_start = 0, n_vld = 0, bad_data = 0, viol_rd = 0, n_nap_rise = 0;
  int cnv_w = 0, last_cnv_w = 0, rd_w = 0, last_rd_w = 0;
  bit p_cnv = 1, p_cs = 1, p_rd = 1, p_busy = 1, p_vld = 0, p_nap = 0, p_stby = 0, p_nr = 0;

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      cyc++;
      if (!cnv_n) begin
        cnv_w = p_cnv ? 1 : cnv_w + 1;
        if (p_cnv) begin t_cnv_prev = t_cnv; t_cnv = cyc; n_start++; end
      end else if (!p_cnv) last_cnv_w = cnv_w;
      if (!rd_n) begin
        rd_w = p_rd ? 1 : rd_w + 1;
        if (p_rd) t_rdf = cyc;
      end else if (!p_rd) last_rd_w = rd_w;
      if (cs_n && !p_cs) t_csr = cyc;
      if (busy && !p_busy) t_busyr = cyc;
      if ((!rd_n && !busy) || (rd_n != cs_n)) viol_rd++;
      if (data_vld) begin
        if ({ovr, data} != mkw(n_vld) || p_vld) bad_data++;
        n_vld++;
      end
      if (nap_pin && !p_nap) n_nap_rise++;
      if (!nap_pin && p_nap) t_napf = cyc;
      if (!stby_pin && p_stby) t_stbyf = cyc;
      if (!not_ready && p_nr) t_nrf = cyc;
      p_cnv = cnv_n; p_cs = cs_n; p_rd = rd_n; p_busy = busy; p_vld = data_vld;
      p_nap = nap_pin; p_stby = stby_pin; p_nr = not_ready;
    end
  end

  task automatic t_reset;
    repeat (3) @(posedge clk); #2;
    chk(cnv_n && cs_n && rd_n, "R11 bus strobes high in reset", {cnv_n, cs_n, rd_n}, 7);
    chk(!nap_pin && !stby_pin, "R11 power pins low in reset", {nap_pin, stby_pin}, 0);
    chk(!data_vld && !not_ready, "R11 vld/not_ready low in reset", {data_vld, not_ready}, 0);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic t_disabled;
    repeat (100) @(posedge clk); #2;
    chk(n_start == 0, "R12 no start while disabled", n_start, 0);
  endtask

  task automatic t_periodic;
    @(negedge clk) begin period = 16'd40; sample_en = 1; end
    wait (n_start >= 4);
    repeat (30) @(posedge clk); #2;
    chk(t_cnv - t_cnv_prev == 40, "R1 start spacing", t_cnv - t_cnv_prev, 40);
    chk(last_cnv_w == T_CNV, "R1 start pulse width", last_cnv_w, T_CNV);
    chk(viol_rd == 0, "R2 read only with busy high", viol_rd, 0);
    chk(t_rdf == t_busyr, "R2 read follows busy rise", t_rdf, t_busyr);
    chk(last_rd_w == T_RD, "R2 read width", last_rd_w, T_RD);
    chk(n_vld == n_start, "R3 one valid per conversion", n_vld, n_start);
    chk(bad_data == 0, "R3 captured word and overrange", bad_data, 0);
  endtask

  task automatic t_back_to_back;
    int s;
    @(negedge clk) period = 16'd1;
    s = n_start;
    wait (n_start >= s + 3);
    chk(t_cnv - t_csr == T_QUIET + 1, "R4 quiet gap", t_cnv - t_csr, T_QUIET + 1);
    @(negedge clk) period = 16'd40;
    repeat (60) @(posedge clk);
  endtask

  task automatic t_nap;
    int s;
    @(negedge clk) begin ref_internal = 0; pwr_req = 2'b01; end
    wait (nap_pin);
    s = n_start;
    repeat (100) @(posedge clk); #2;
    chk(n_start == s, "R5 no start during nap", n_start, s);
    chk(nap_pin && not_ready, "R5 nap pin and not_ready", {nap_pin, not_ready}, 3);
    @(negedge clk) pwr_req = 2'b00;
    wait (n_start == s + 1);
    chk(t_cnv - t_napf == T_NAP + 1, "R6 start after nap wake", t_cnv - t_napf, T_NAP + 1);
    chk(t_nrf - t_napf == T_NAP, "R6 not_ready during nap wake", t_nrf - t_napf, T_NAP);
  endtask

  task automatic t_midconv;
    int s, v;
    s = n_start;
    wait (n_start == s + 1);
    v = n_vld;
    @(negedge clk) pwr_req = 2'b01;
    wait (nap_pin);
    #1;
    chk(n_vld == v + 1, "R10 word delivered before nap", n_vld, v + 1);
    chk(bad_data == 0, "R10 word intact", bad_data, 0);
    @(negedge clk) pwr_req = 2'b00;
    repeat (80) @(posedge clk);
  endtask

  task automatic t_reject;
    int s, r;
    s = n_start; r = n_nap_rise;
    @(negedge clk) begin ref_internal = 1; pwr_req = 2'b01; end
    repeat (200) @(posedge clk); #2;
    chk(n_nap_rise == r, "R7 nap pin stays low", n_nap_rise, r);
    chk(nap_reject == 1'b1, "R7 reject flag", nap_reject, 1);
    chk(n_start > s + 2, "R7 sampling continues", n_start, s + 3);
    @(negedge clk) begin pwr_req = 2'b00; ref_internal = 0; end
    repeat (50) @(posedge clk);
  endtask

  task automatic t_standby;
    int s;
    @(negedge clk) pwr_req = 2'b01;
    wait (nap_pin);
    @(negedge clk) pwr_req = 2'b11;
    repeat (3) @(posedge clk); #2;
    chk(stby_pin && !nap_pin, "R8 standby overrides nap", {stby_pin, nap_pin}, 2);
    @(negedge clk) ref_internal = 1;
    repeat (20) @(posedge clk);
    s = n_start;
    @(negedge clk) pwr_req = 2'b00;
    wait (n_start == s + 1);
    chk(t_cnv - t_stbyf == T_SI + 1, "R9 standby wake internal ref", t_cnv - t_stbyf, T_SI + 1);
    @(negedge clk) begin ref_internal = 0; pwr_req = 2'b10; end
    wait (stby_pin);
    repeat (50) @(posedge clk);
    s = n_start;
    @(negedge clk) pwr_req = 2'b00;
    wait (n_start == s + 1);
    chk(t_cnv - t_stbyf == T_SE + 1, "R9 standby wake external ref", t_cnv - t_stbyf, T_SE + 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    t_reset();
    t_disabled();
    t_periodic();
    t_back_to_back();
    t_nap();
    t_midconv();
    t_reject();
    t_standby();
    repeat (20) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule